// File: doc/BRIEF.md
# PPS Phase-Lag Disciplining Counter

The block disciplines a local oscillator to a one-pulse-per-second reference. A fast sample clock runs the whole block. After every reference pulse the block counts how many sample cycles pass before the next rising edge of the oscillator signal. It averages a short window of those counts, then turns the average into a 14-bit tuning word for an external DAC. The tuning word is proportional to the lag error. Long-term smoothing is left to a passive filter placed after the DAC.

A small controller has three states: tracking, locked and searching. In the searching state the proportional update is suspended. Instead, the tuning word is stepped by a fixed amount on every reference pulse, and it wraps at full scale, until a lag inside the lock window is seen again. The raw measurement is also brought out, with a strobe and a validity flag.

Top module: `pps_lag_discipliner`

## Requirements
- R1: Both inputs go through two-flop synchronizers. A rise is detected when the second stage is 1 and the third stage is 0. The lag is the number of sample cycles from the detected PPS rise to the first oscillator rise detected after it. `meas_stb_o` pulses for one cycle, with `meas_ok_o`=1 and `meas_lag_o`=lag. When both inputs rise together k cycles apart (1 ≤ k ≤ 20), the strobe is seen in the cycle that follows the (k+3)-th clock edge after the PPS input rises.
- R2: An oscillator rise detected in the same cycle as the PPS rise does not end the count. If no oscillator rise arrives by the time the count reaches MAX_LAG (20), the measurement ends with `meas_ok_o`=0.
- R3: After reset, `dac_code_o`=8192 (mid-scale), and `dac_load_o`, `locked_o`, `searching_o` and `meas_stb_o` are all 0.
- R4: Outside the searching state, valid measurements are summed in windows of 2^AVG_LOG2 (4). Invalid measurements are skipped. On the strobe of the last measurement in a window, the tuning word is updated and `dac_load_o` pulses. Both are visible one cycle after that strobe.
- R5: The updated word is 8192 + GAIN·(floor(sum/4) − 10), clamped to the range 0 to 16383.
- R6: A measurement is "in window" when it is valid and its lag is between 8 and 12. Eight consecutive in-window measurements move the state from tracking to locked (`locked_o`=1).
- R7: Four consecutive measurements that are not in window (out of range or invalid) move the block to the searching state: `searching_o`=1 and `locked_o`=0. The tuning word is left unchanged on that transition.
- R8: If no PPS rise is detected for 2·SEC_CYCLES sample cycles, the block enters the searching state.
- R9: While searching, every measurement that is not in window adds STEP to the tuning word, modulo 16384, and pulses `dac_load_o`.
- R10: While searching, an in-window measurement returns the block to tracking, with the tuning word left unchanged. The averaging window then starts empty.
- R11: `locked_o` and `searching_o` are never 1 together. `dac_code_o` changes only in a cycle where `dac_load_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock (about 200 MHz) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pps_i | input | 1 | One-pulse-per-second reference, asynchronous |
| osc_i | input | 1 | Oscillator signal or a divided-down copy of it, asynchronous |
| dac_code_o | output | CODE_W | Tuning word for the external DAC |
| dac_load_o | output | 1 | One-cycle pulse when the tuning word is rewritten |
| locked_o | output | 1 | Loop is in the locked state |
| searching_o | output | 1 | Loop is sweeping the tuning word |
| meas_stb_o | output | 1 | One-cycle pulse when a lag measurement ends |
| meas_ok_o | output | 1 | The measurement ended on an oscillator edge |
| meas_lag_o | output | LAG_W | Measured lag in sample cycles |

## Verification
Every measurement result is due in a fixed cycle. For a drive offset of k cycles, the strobe, validity and lag appear after the (k+3)-th rising edge that follows the PPS drive. For a timed-out measurement they appear after the 23rd edge. The tuning word, the load pulse and the state flags follow exactly one edge later. The bench drives both inputs on falling edges and counts rising edges in one loop per pulse. It samples on the falling edge at those two points and compares against values worked out from the averaging and mapping formula. The missing-pulse timeout is checked with margin on both sides of its threshold: not yet searching well before 2·SEC_CYCLES, and searching well after it.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [1:0] {
    ST_TRACK  = 2'd0,
    ST_LOCKED = 2'd1,
    ST_SEARCH = 2'd2
  } pld_state_e;
endpackage

// File: rtl/pld_sync_edge.sv
module pld_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pld_lag_meter.sv
module pld_lag_meter #(
  parameter int MAX_LAG = 20,
  parameter int LAG_W   = $clog2(MAX_LAG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             stb_o,
  output logic             ok_o,
  output logic [LAG_W-1:0] lag_o
);
  logic             busy_q;
  logic [LAG_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      stb_o  <= 1'b0;
      ok_o   <= 1'b0;
      lag_o  <= '0;
    end else begin
      stb_o <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= LAG_W'(1);
      end else if (busy_q) begin
        if (stop_i) begin
          busy_q <= 1'b0;
          stb_o  <= 1'b1;
          ok_o   <= 1'b1;
          lag_o  <= cnt_q;
        end else if (cnt_q == LAG_W'(MAX_LAG)) begin
          busy_q <= 1'b0;
          stb_o  <= 1'b1;
          ok_o   <= 1'b0;
          lag_o  <= cnt_q;
        end else begin
          cnt_q <= cnt_q + LAG_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pld_avg_map.sv
module pld_avg_map #(
  parameter int LAG_W    = 5,
  parameter int AVG_LOG2 = 2,
  parameter int CODE_W   = 14,
  parameter int TARGET   = 10,
  parameter int GAIN     = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              add_i,
  input  logic [LAG_W-1:0]  lag_i,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int ACC_W = LAG_W + AVG_LOG2;
  localparam int MID   = 1 << (CODE_W - 1);
  localparam int FULL  = (1 << CODE_W) - 1;

  logic [ACC_W-1:0]    acc_q;
  logic [AVG_LOG2-1:0] n_q;
  logic [ACC_W-1:0]    sum;
  logic [LAG_W-1:0]    avg;
  logic signed [31:0]  diff, val;

  assign sum    = acc_q + ACC_W'(lag_i);
  assign avg    = LAG_W'(sum >> AVG_LOG2);
  assign done_o = add_i && (n_q == {AVG_LOG2{1'b1}});

  always_comb begin
    diff = $signed(32'(avg)) - 32'(TARGET);
    val  = 32'(MID) + 32'(GAIN) * diff;
    if (val < 0)             code_o = '0;
    else if (val > 32'(FULL)) code_o = CODE_W'(FULL);
    else                     code_o = val[CODE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      n_q   <= '0;
    end else if (clear_i) begin
      acc_q <= '0;
      n_q   <= '0;
    end else if (add_i) begin
      acc_q <= done_o ? '0 : sum;
      n_q   <= n_q + 1'b1;
    end
  end
endmodule

// File: rtl/pld_lock_ctrl.sv
module pld_lock_ctrl
  import pld_pkg::*;
#(
  parameter int LAG_W      = 5,
  parameter int CODE_W     = 14,
  parameter int TARGET     = 10,
  parameter int WIN        = 2,
  parameter int LOCK_N     = 8,
  parameter int LOSS_N     = 4,
  parameter int STEP       = 512,
  parameter int SEC_CYCLES = 200_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pps_rise_i,
  input  logic              meas_stb_i,
  input  logic              meas_ok_i,
  input  logic [LAG_W-1:0]  meas_lag_i,
  input  logic              avg_done_i,
  input  logic [CODE_W-1:0] avg_code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              load_o,
  output pld_state_e        state_o
);
  localparam int TMO    = 2 * SEC_CYCLES;
  localparam int MISS_W = $clog2(TMO + 1);
  localparam int GOOD_W = $clog2(LOCK_N + 1);
  localparam int BAD_W  = $clog2(LOSS_N + 1);

  logic [MISS_W-1:0] miss_q;
  logic [GOOD_W-1:0] good_q;
  logic [BAD_W-1:0]  bad_q;
  logic              in_win, lost, timeout;

  assign in_win  = meas_ok_i && (int'(meas_lag_i) >= TARGET - WIN) &&
                   (int'(meas_lag_i) <= TARGET + WIN);
  assign lost    = meas_stb_i && !in_win && (bad_q == BAD_W'(LOSS_N - 1));
  assign timeout = (miss_q == MISS_W'(TMO));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         miss_q <= '0;
    else if (pps_rise_i) miss_q <= '0;
    else if (!timeout)   miss_q <= miss_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_TRACK;
      code_o  <= CODE_W'(1 << (CODE_W - 1));
      load_o  <= 1'b0;
      good_q  <= '0;
      bad_q   <= '0;
    end else begin
      load_o <= 1'b0;
      if (state_o == ST_SEARCH) begin
        if (meas_stb_i) begin
          if (in_win) begin
            state_o <= ST_TRACK;
            good_q  <= '0;
            bad_q   <= '0;
          end else begin
            code_o <= code_o + CODE_W'(STEP);  // wraps at full scale
            load_o <= 1'b1;
          end
        end
      end else if (timeout || lost) begin
        state_o <= ST_SEARCH;
        good_q  <= '0;
        bad_q   <= '0;
      end else begin
        if (meas_stb_i) begin
          if (in_win) begin
            bad_q <= '0;
            if (good_q == GOOD_W'(LOCK_N - 1)) state_o <= ST_LOCKED;
            else                               good_q  <= good_q + 1'b1;
          end else begin
            good_q <= '0;
            bad_q  <= bad_q + 1'b1;
          end
        end
        if (avg_done_i) begin
          code_o <= avg_code_i;
          load_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pps_lag_discipliner.sv
module pps_lag_discipliner
  import pld_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_LAG     = 20,
  parameter int AVG_LOG2    = 2,
  parameter int CODE_W      = 14,
  parameter int TARGET      = 10,
  parameter int GAIN        = 400,
  parameter int WIN         = 2,
  parameter int LOCK_N      = 8,
  parameter int LOSS_N      = 4,
  parameter int STEP        = 512,
  parameter int SEC_CYCLES  = 200_000_000,
  localparam int LAG_W      = $clog2(MAX_LAG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pps_i,
  input  logic              osc_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              dac_load_o,
  output logic              locked_o,
  output logic              searching_o,
  output logic              meas_stb_o,
  output logic              meas_ok_o,
  output logic [LAG_W-1:0]  meas_lag_o
);
  logic              pps_rise, osc_rise, avg_done, avg_add;
  logic [CODE_W-1:0] avg_code;
  pld_state_e        state;

  pld_sync_edge #(.STAGES(SYNC_STAGES)) i_pps_sync (
    .clk_i, .rst_ni, .d_i(pps_i), .rise_o(pps_rise)
  );
  pld_sync_edge #(.STAGES(SYNC_STAGES)) i_osc_sync (
    .clk_i, .rst_ni, .d_i(osc_i), .rise_o(osc_rise)
  );

  pld_lag_meter #(.MAX_LAG(MAX_LAG), .LAG_W(LAG_W)) i_meter (
    .clk_i, .rst_ni, .start_i(pps_rise), .stop_i(osc_rise),
    .stb_o(meas_stb_o), .ok_o(meas_ok_o), .lag_o(meas_lag_o)
  );

  assign avg_add = meas_stb_o && meas_ok_o && (state != ST_SEARCH);

  pld_avg_map #(
    .LAG_W(LAG_W), .AVG_LOG2(AVG_LOG2), .CODE_W(CODE_W),
    .TARGET(TARGET), .GAIN(GAIN)
  ) i_avg (
    .clk_i, .rst_ni, .clear_i(state == ST_SEARCH), .add_i(avg_add),
    .lag_i(meas_lag_o), .done_o(avg_done), .code_o(avg_code)
  );

  pld_lock_ctrl #(
    .LAG_W(LAG_W), .CODE_W(CODE_W), .TARGET(TARGET), .WIN(WIN),
    .LOCK_N(LOCK_N), .LOSS_N(LOSS_N), .STEP(STEP), .SEC_CYCLES(SEC_CYCLES)
  ) i_ctrl (
    .clk_i, .rst_ni, .pps_rise_i(pps_rise), .meas_stb_i(meas_stb_o),
    .meas_ok_i(meas_ok_o), .meas_lag_i(meas_lag_o), .avg_done_i(avg_done),
    .avg_code_i(avg_code), .code_o(dac_code_o), .load_o(dac_load_o),
    .state_o(state)
  );

  assign locked_o    = (state == ST_LOCKED);
  assign searching_o = (state == ST_SEARCH);
endmodule

// File: rtl/pld_chk.sv
module pld_chk #(
  parameter int CODE_W  = 14,
  parameter int MAX_LAG = 20,
  parameter int LAG_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              dac_load_o,
  input logic              locked_o,
  input logic              searching_o,
  input logic              meas_stb_o,
  input logic              meas_ok_o,
  input logic [LAG_W-1:0]  meas_lag_o
);
  // R11
  state_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({locked_o, searching_o}));
  // R11
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_code_o) |-> dac_load_o);
  // R2
  lag_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_stb_o && meas_ok_o) |-> (meas_lag_o >= LAG_W'(1) && meas_lag_o <= LAG_W'(MAX_LAG)));
  // R4
  load_after_meas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_load_o |-> $past(meas_stb_o));
  // R6
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(meas_stb_o && meas_ok_o));
  // R10
  search_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(searching_o) |-> $past(meas_stb_o && meas_ok_o));
endmodule

bind pps_lag_discipliner pld_chk #(
  .CODE_W(CODE_W), .MAX_LAG(MAX_LAG), .LAG_W(LAG_W)
) i_pld_chk (
  .clk_i, .rst_ni, .dac_code_o, .dac_load_o, .locked_o, .searching_o,
  .meas_stb_o, .meas_ok_o, .meas_lag_o
);

// File: tb/test_pps_lag_discipliner.sv
module test_pps_lag_discipliner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pps = 1'b0;
  logic        osc = 1'b0;
  logic [13:0] code;
  logic        load, locked, srch, stb, ok;
  logic [4:0]  lag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pps_lag_discipliner #(
    .GAIN(1200), .STEP(5000), .SEC_CYCLES(100)
  ) i_pps_lag_discipliner (
    .clk_i(clk), .rst_ni(rst_n), .pps_i(pps), .osc_i(osc),
    .dac_code_o(code), .dac_load_o(load), .locked_o(locked),
    .searching_o(srch), .meas_stb_o(stb), .meas_ok_o(ok), .meas_lag_o(lag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one PPS with oscillator rise k cycles later; k=0 coincident, k>20 none
  task automatic pulse(input int k, input bit exp_ok, input string req);
    int n;
    n = (k == 0 || k > 20) ? 23 : k + 3;
    for (int c = 0; c < n; c++) begin
      if (c == 0) pps = 1'b1;
      if (c == k && k <= 20) osc = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    chk({req, " meas strobe"}, int'(stb), 1);
    chk({req, " meas ok"}, int'(ok), int'(exp_ok));
    if (exp_ok) chk({req, " meas lag"}, int'(lag), k);
    @(posedge clk);
    @(negedge clk);
    pps = 1'b0;
    osc = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic after(input string req, input int e_code, input int e_load,
                       input int e_lock, input int e_srch);
    chk({req, " code"}, int'(code), e_code);
    chk({req, " load"}, int'(load), e_load);
    chk({req, " locked"}, int'(locked), e_lock);
    chk({req, " searching"}, int'(srch), e_srch);
  endtask

  // {lag k, expected code, load, locked} for R1/R4/R5/R6
  localparam int TAB [8][4] = '{
    '{11, 8192, 0, 0}, '{ 9, 8192, 0, 0}, '{12, 8192, 0, 0}, '{10, 8192, 1, 0},
    '{ 8, 8192, 0, 0}, '{12, 8192, 0, 0}, '{12, 8192, 0, 0}, '{12, 9392, 1, 1}
  };

  // pulse then state one edge after the strobe
  task automatic step(input int k, input bit eok, input string req, input int e_code,
                      input int e_load, input int e_lock, input int e_srch);
    int n;
    n = (k == 0 || k > 20) ? 23 : k + 3;
    for (int c = 0; c < n; c++) begin
      if (c == 0) pps = 1'b1;
      if (c == k && k <= 20) osc = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    chk({req, " meas strobe"}, int'(stb), 1);
    chk({req, " meas ok"}, int'(ok), int'(eok));
    if (eok) chk({req, " meas lag"}, int'(lag), k);
    @(posedge clk);
    @(negedge clk);
    after(req, e_code, e_load, e_lock, e_srch);
    pps = 1'b0;
    osc = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R3 reset state
    after("R3", 8192, 0, 0, 0);
    chk("R3 strobe", int'(stb), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++)
      step(TAB[i][0], 1'b1, "R1/R4/R5/R6", TAB[i][1], TAB[i][2], TAB[i][3], 0);

    // R5 clamp high: avg 18 -> 17792 clipped
    step(20, 1, "R5", 9392, 0, 1, 0);
    step(20, 1, "R5", 9392, 0, 1, 0);
    step(20, 1, "R5", 9392, 0, 1, 0);
    step(12, 1, "R5 high clamp", 16383, 1, 1, 0);
    // R5 clamp low: avg 3 -> negative clipped
    step(1, 1, "R5", 16383, 0, 1, 0);
    step(1, 1, "R5", 16383, 0, 1, 0);
    step(1, 1, "R5", 16383, 0, 1, 0);
    step(10, 1, "R5 low clamp", 0, 1, 1, 0);

    // R2 timeout and coincident edge; R7 loss after four bad
    step(25, 0, "R2 timeout", 0, 0, 1, 0);
    step(0, 0, "R2 coincident", 0, 0, 1, 0);
    step(25, 0, "R7", 0, 0, 1, 0);
    step(25, 0, "R7 loss", 0, 0, 0, 1);

    // R9 sweep with wrap
    step(20, 1, "R9", 5000, 1, 0, 1);
    step(25, 0, "R9", 10000, 1, 0, 1);
    step(3, 1, "R9", 15000, 1, 0, 1);
    step(15, 1, "R9 wrap", 3616, 1, 0, 1);

    // R10 exit, fresh window
    step(10, 1, "R10 exit", 3616, 0, 0, 0);
    step(9, 1, "R10", 3616, 0, 0, 0);
    step(9, 1, "R10", 3616, 0, 0, 0);
    step(9, 1, "R10", 3616, 0, 0, 0);
    step(9, 1, "R10 window", 6992, 1, 0, 0);

    // R8 missing PPS
    repeat (150) @(negedge clk);
    chk("R8 before timeout", int'(srch), 0);
    repeat (100) @(negedge clk);
    chk("R8 after timeout", int'(srch), 1);
    chk("R11 code held", int'(code), 6992);

    // R3 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    after("R3 re-reset", 8192, 0, 0, 0);
    rst_n = 1'b1;
    pulse(5, 1'b1, "R1 after reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule